// File: doc/BRIEF.md
# Parallel Subarray Address Generator

This block sits in front of an interleaved image buffer of M rows by N columns spread over K memory modules. For one start coordinate and one shape it works out, in a single pipelined pass, the word address each module must use and which point of the shape each module serves. With that, the buffer can read or write P·Q image points in one access. Five shapes are available: a P×Q block, a horizontal run, a vertical run, a forward diagonal and a backward diagonal. Each run and diagonal is P·Q points long.

Point (r,c) lives in module (r·Q + c) mod K, at in-module word r·N + c. Every served address is a base plus an offset. The base is r·N + c of the start point. It takes the row product from a shift when N is a power of two, and from a constant row table otherwise. The offset comes from a loadable table indexed by shape and by the module's position relative to the start module. A second loadable table gives the routing entry.

Software fills both tables once through a small write port before any access. After a start strobe, results appear two clock cycles later. A new access may start every cycle.

Top module: `subarray_addr_gen`

## Requirements
- R1: Shape codes on `shapeSel` are 0 block (P rows × Q columns), 1 horizontal run (1 × P·Q), 2 vertical run (P·Q × 1), 3 forward diagonal (points (r+k, c+k)) and 4 backward diagonal (points (r+k, c−k)). For each shape, k = 0..P·Q−1, and for the block k = di·Q + dj.
- R2: For every point (r',c') of a legal access, the module serving it outputs address r'·N + c' on its `modAddr` lane.
- R3: With tables loaded for the default sizes, the points of a legal access fall in P·Q distinct modules, and exactly P·Q `modUsed` flags are set.
- R4: `modPoint[m]` gives the index k of the point that module m serves, and `modUsed[m]` is 1 exactly for modules that serve a point.
- R5: `outValid` goes high in the cycle two clock edges after the edge that samples `start`, for one cycle per start. Back-to-back starts give back-to-back results, and the outputs hold when no result is committed.
- R6: `outErr` is set together with `outValid` when the shape would reach past row M−1 or column N−1, or before column 0, or when the shape code is above 4.
- R7: The table write port stores into entry `tblIdx` = shape·K + rel. `tblSel`=0 selects the offset table (data bits AW−1:0). `tblSel`=1 selects the routing table: bit PIW is the used flag and bits PIW−1:0 the point index. Indices at or above 5·K are ignored.
- R8: Module m reads the table entry at rel = (m − m0) mod K, where m0 = (r·Q + c) mod K is the start point's module.
- R9: After reset, `outValid` and `outErr` are 0, and all `modUsed` flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an access this cycle |
| startRow | input | RW | Row r of the start point |
| startCol | input | CW | Column c of the start point |
| shapeSel | input | 3 | Shape code (R1) |
| tblWe | input | 1 | Table write enable |
| tblSel | input | 1 | 0 offset table, 1 routing table |
| tblIdx | input | TIW | Table entry shape·K + rel |
| tblData | input | DW | Table write data |
| outValid | output | 1 | Results valid |
| outErr | output | 1 | Access out of range or bad shape |
| modAddr | output | K×AW | Word address per module |
| modPoint | output | K×PIW | Point index served per module |
| modUsed | output | K | Module serves a point |

## Verification
The hardest cases are the wrap of the relative module index and the boundary of each shape. The wrap happens when the start module m0 sits near K−1, so that served modules cross from K−1 back to 0. The boundary case is a backward diagonal that must start at column P·Q−1 or beyond. Reaching each m0 for each shape by hand would be tedious. The bench therefore sweeps every shape over every row and column of a small 8×6 buffer, which covers every m0 and every edge, both legal and illegal. It also issues two starts on consecutive cycles to reach the pipelined overlap.

// File: rtl/subarray_pkg.sv
package subarray_pkg;
  localparam int NUM_SHAPES = 5;

  typedef enum logic [2:0] {
    SHP_BLOCK = 3'd0,
    SHP_ROW   = 3'd1,
    SHP_COL   = 3'd2,
    SHP_FWD   = 3'd3,
    SHP_BWD   = 3'd4
  } shapeT;

  typedef struct packed {
    logic capture;
    logic commit;
  } ctlStrobeT;
endpackage

// File: rtl/subarray_ctrl.sv
module subarray_ctrl
  import subarray_pkg::*;
#(
  parameter int M = 8,
  parameter int N = 6,
  parameter int P = 2,
  parameter int Q = 2,
  localparam int PQ = P * Q,
  localparam int RW = (M > 1) ? $clog2(M) : 1,
  localparam int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [RW-1:0] startRow,
  input  logic [CW-1:0] startCol,
  input  logic [2:0]    shapeSel,
  output ctlStrobeT     strb,
  output logic          outValid,
  output logic          outErr
);
  logic s1Valid, s1Err, rangeBad;

  always_comb begin
    int rowReach, colReach, colBack;
    rowReach = 0;
    colReach = 0;
    colBack  = 0;
    rangeBad = 1'b0;
    case (shapeSel)
      SHP_BLOCK: begin rowReach = P - 1;  colReach = Q - 1;  end
      SHP_ROW:   begin colReach = PQ - 1; end
      SHP_COL:   begin rowReach = PQ - 1; end
      SHP_FWD:   begin rowReach = PQ - 1; colReach = PQ - 1; end
      SHP_BWD:   begin rowReach = PQ - 1; colBack  = PQ - 1; end
      default:   rangeBad = 1'b1;
    endcase
    if (int'(startRow) + rowReach >= M) rangeBad = 1'b1;
    if (int'(startCol) + colReach >= N) rangeBad = 1'b1;
    if (int'(startCol) < colBack)       rangeBad = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Valid  <= 1'b0;
      s1Err    <= 1'b0;
      outValid <= 1'b0;
      outErr   <= 1'b0;
    end else begin
      s1Valid  <= start;
      s1Err    <= start & rangeBad;
      outValid <= s1Valid;
      outErr   <= s1Valid & s1Err;
    end
  end

  assign strb.capture = start;
  assign strb.commit  = s1Valid;

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(start, 2)); // R5
  AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    outErr |-> outValid); // R6
endmodule

// File: rtl/subarray_datapath.sv
module subarray_datapath
  import subarray_pkg::*;
#(
  parameter int M = 8,
  parameter int N = 6,
  parameter int P = 2,
  parameter int Q = 2,
  parameter int K = 5,
  localparam int PQ  = P * Q,
  localparam int RW  = (M > 1) ? $clog2(M) : 1,
  localparam int CW  = (N > 1) ? $clog2(N) : 1,
  localparam int AW  = $clog2(M * N),
  localparam int PIW = (PQ > 1) ? $clog2(PQ) : 1,
  localparam int DEPTH = NUM_SHAPES * K,
  localparam int TIW = $clog2(DEPTH),
  localparam int DW  = (AW > PIW + 1) ? AW : PIW + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  ctlStrobeT               strb,
  input  logic [RW-1:0]           startRow,
  input  logic [CW-1:0]           startCol,
  input  logic [2:0]              shapeSel,
  input  logic                    tblWe,
  input  logic                    tblSel,
  input  logic [TIW-1:0]          tblIdx,
  input  logic [DW-1:0]           tblData,
  output logic [K-1:0][AW-1:0]    modAddr,
  output logic [K-1:0][PIW-1:0]   modPoint,
  output logic [K-1:0]            modUsed
);
  localparam bit N_POW2 = (N & (N - 1)) == 0;
  localparam int NSH = (N > 1) ? $clog2(N) : 0;

  logic [AW-1:0]  offTbl   [DEPTH];
  logic [PIW:0]   routeTbl [DEPTH];
  logic [AW-1:0]  rowBase, baseS1;
  logic [K-1:0][AW-1:0] offS1;
  logic [K-1:0][PIW:0]  rtS1;
  logic [K-1:0][TIW-1:0] rdIdx;
  logic [K-1:0]          rdOk;

  // Row product: shift for power-of-two width, constant row table otherwise
  generate
    if (N_POW2) begin : g_shift
      assign rowBase = AW'(startRow) << NSH;
    end else begin : g_rowtbl
      logic [AW-1:0] rowTbl [M];
      always_comb begin
        for (int r = 0; r < M; r++) rowTbl[r] = AW'(r * N);
      end
      assign rowBase = (int'(startRow) < M) ? rowTbl[startRow] : '0;
    end
  endgenerate

  // Relative module index per module lane
  always_comb begin
    int m0, rel, idx;
    m0 = (int'(startRow) * Q + int'(startCol)) % K;
    for (int m = 0; m < K; m++) begin
      rel = (m - m0 + K) % K;
      idx = int'(shapeSel) * K + rel;
      rdOk[m]  = idx < DEPTH;
      rdIdx[m] = rdOk[m] ? TIW'(idx) : '0;
    end
  end

  // Table write port
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < DEPTH; e++) begin
        offTbl[e]   <= '0;
        routeTbl[e] <= '0;
      end
    end else if (tblWe && int'(tblIdx) < DEPTH) begin
      if (tblSel) routeTbl[tblIdx] <= tblData[PIW:0];
      else        offTbl[tblIdx]   <= tblData[AW-1:0];
    end
  end

  // Stage 1: base and both table reads in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      baseS1 <= '0;
      offS1  <= '0;
      rtS1   <= '0;
    end else if (strb.capture) begin
      baseS1 <= rowBase + AW'(startCol);
      for (int m = 0; m < K; m++) begin
        offS1[m] <= rdOk[m] ? offTbl[rdIdx[m]]   : '0;
        rtS1[m]  <= rdOk[m] ? routeTbl[rdIdx[m]] : '0;
      end
    end
  end

  // Stage 2: one adder per module lane
  genvar g;
  generate
    for (g = 0; g < K; g++) begin : g_lane
      always_ff @(posedge clk) begin
        if (rst) begin
          modAddr[g]  <= '0;
          modPoint[g] <= '0;
          modUsed[g]  <= 1'b0;
        end else if (strb.commit) begin
          modAddr[g]  <= baseS1 + offS1[g];
          modPoint[g] <= rtS1[g][PIW-1:0];
          modUsed[g]  <= rtS1[g][PIW];
        end
      end
    end
  endgenerate

  AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !strb.commit |=> $stable(modAddr) && $stable(modUsed)); // R5
  AST_TBL_INDEX: assert property (@(posedge clk) disable iff (rst)
    (tblWe && int'(tblIdx) >= DEPTH) |=> $stable(modUsed) || $past(strb.commit)); // R7
endmodule

// File: rtl/subarray_addr_gen.sv
module subarray_addr_gen
  import subarray_pkg::*;
#(
  parameter int M = 8,
  parameter int N = 6,
  parameter int P = 2,
  parameter int Q = 2,
  parameter int K = 5,
  localparam int PQ  = P * Q,
  localparam int RW  = (M > 1) ? $clog2(M) : 1,
  localparam int CW  = (N > 1) ? $clog2(N) : 1,
  localparam int AW  = $clog2(M * N),
  localparam int PIW = (PQ > 1) ? $clog2(PQ) : 1,
  localparam int TIW = $clog2(NUM_SHAPES * K),
  localparam int DW  = (AW > PIW + 1) ? AW : PIW + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [RW-1:0]         startRow,
  input  logic [CW-1:0]         startCol,
  input  logic [2:0]            shapeSel,
  input  logic                  tblWe,
  input  logic                  tblSel,
  input  logic [TIW-1:0]        tblIdx,
  input  logic [DW-1:0]         tblData,
  output logic                  outValid,
  output logic                  outErr,
  output logic [K-1:0][AW-1:0]  modAddr,
  output logic [K-1:0][PIW-1:0] modPoint,
  output logic [K-1:0]          modUsed
);
  ctlStrobeT strb;

  subarray_ctrl #(.M(M), .N(N), .P(P), .Q(Q)) ctrl_i (
    .clk(clk), .rst(rst), .start(start), .startRow(startRow),
    .startCol(startCol), .shapeSel(shapeSel), .strb(strb),
    .outValid(outValid), .outErr(outErr)
  );

  subarray_datapath #(.M(M), .N(N), .P(P), .Q(Q), .K(K)) dp_i (
    .clk(clk), .rst(rst), .strb(strb), .startRow(startRow),
    .startCol(startCol), .shapeSel(shapeSel), .tblWe(tblWe),
    .tblSel(tblSel), .tblIdx(tblIdx), .tblData(tblData),
    .modAddr(modAddr), .modPoint(modPoint), .modUsed(modUsed)
  );
endmodule

// File: tb/subarray_addr_gen_tb.sv
module subarray_addr_gen_tb_top;
  localparam int M = 8, N = 6, P = 2, Q = 2, K = 5;
  localparam int PQ = P * Q;
  localparam int RW = 3, CW = 3, AW = 6, PIW = 2, TIW = 5, DW = 6;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [RW-1:0] startRow = '0;
  logic [CW-1:0] startCol = '0;
  logic [2:0] shapeSel = '0;
  logic tblWe = 1'b0, tblSel = 1'b0;
  logic [TIW-1:0] tblIdx = '0;
  logic [DW-1:0] tblData = '0;
  logic outValid, outErr;
  logic [K-1:0][AW-1:0] modAddr;
  logic [K-1:0][PIW-1:0] modPoint;
  logic [K-1:0] modUsed;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  subarray_addr_gen dut_i (
    .clk(clk), .rst(rst), .start(start), .startRow(startRow), .startCol(startCol),
    .shapeSel(shapeSel), .tblWe(tblWe), .tblSel(tblSel), .tblIdx(tblIdx),
    .tblData(tblData), .outValid(outValid), .outErr(outErr), .modAddr(modAddr),
    .modPoint(modPoint), .modUsed(modUsed)
  );

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R1 point k of shape sh relative to the start point
  function automatic void pointDelta(int sh, int k, output int di, output int dj);
    case (sh)
      0: begin di = k / Q; dj = k % Q; end
      1: begin di = 0; dj = k; end
      2: begin di = k; dj = 0; end
      3: begin di = k; dj = k; end
      default: begin di = k; dj = -k; end
    endcase
  endfunction

  function automatic bit isLegal(int sh, int r, int c);
    int di, dj;
    if (sh > 4) return 0;
    for (int k = 0; k < PQ; k++) begin
      pointDelta(sh, k, di, dj);
      if (r + di >= M || c + dj >= N || c + dj < 0) return 0;
    end
    return 1;
  endfunction

  task automatic writeTbl(bit sel, int idx, int data);
    @(negedge clk);
    tblWe = 1'b1; tblSel = sel; tblIdx = TIW'(idx); tblData = DW'(data);
    @(negedge clk);
    tblWe = 1'b0;
  endtask

  task automatic checkResult(int sh, int r, int c);
    int di, dj, m, used;
    bit addrOk, routeOk, distinctOk;
    bit [K-1:0] seen;
    bit legal;
    legal = isLegal(sh, r, c);
    check(outValid === 1'b1, "R5 valid", int'(outValid), 1);
    check(outErr === !legal, "R6 err", int'(outErr), int'(!legal));
    if (legal) begin
      addrOk = 1; routeOk = 1; distinctOk = 1; seen = '0;
      for (int k = 0; k < PQ; k++) begin
        pointDelta(sh, k, di, dj);
        m = ((r + di) * Q + (c + dj)) % K;   // R8 module of the point
        if (seen[m]) distinctOk = 0;
        seen[m] = 1'b1;
        if (int'(modAddr[m]) != (r + di) * N + (c + dj)) begin
          addrOk = 0;
          check(0, "R2 addr", int'(modAddr[m]), (r + di) * N + (c + dj));
        end
        if (!modUsed[m] || int'(modPoint[m]) != k) begin
          routeOk = 0;
          check(0, "R4 route", int'(modPoint[m]), k);
        end
      end
      used = $countones(modUsed);
      if (addrOk) check(1, "R2 addr", 0, 0);
      if (routeOk) check(modUsed == seen, "R4 used", int'(modUsed), int'(seen));
      check(distinctOk && used == PQ, "R3 distinct", used, PQ);
    end
  endtask

  task automatic runOne(int sh, int r, int c);
    @(negedge clk);
    start = 1'b1; shapeSel = 3'(sh); startRow = RW'(r); startCol = CW'(c);
    @(negedge clk);
    start = 1'b0;
    check(outValid === 1'b0, "R5 early", int'(outValid), 0);
    @(negedge clk);
    checkResult(sh, r, c);
    @(negedge clk);
    check(outValid === 1'b0, "R5 single pulse", int'(outValid), 0);
  endtask

  initial begin
    int di, dj, rel;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(outValid === 1'b0, "R9 valid", int'(outValid), 0);
    check(outErr === 1'b0, "R9 err", int'(outErr), 0);
    check(modUsed === '0, "R9 used", int'(modUsed), 0);
    rst = 1'b0;
    // R7 load tables: entry shape*K + rel
    for (int sh = 0; sh < 5; sh++)
      for (int k = 0; k < PQ; k++) begin
        pointDelta(sh, k, di, dj);
        rel = ((di * Q + dj) % K + K) % K;
        writeTbl(0, sh * K + rel, di * N + dj);
        writeTbl(1, sh * K + rel, (1 << PIW) | k);
      end
    // R7 out-of-range index must not disturb entry 0 (block, rel 0)
    writeTbl(1, 31, 0);
    writeTbl(0, 30, 7);
    runOne(0, 0, 0);
    // R1 R2 R3 R4 R6 R8 sweep of every shape and start
    for (int sh = 0; sh < 6; sh++)
      for (int r = 0; r < M; r++)
        for (int c = 0; c < N; c++)
          runOne(sh, r, c);
    // R5 back-to-back starts
    @(negedge clk);
    start = 1'b1; shapeSel = 3'd3; startRow = 3'd1; startCol = 3'd2;
    @(negedge clk);
    shapeSel = 3'd4; startRow = 3'd4; startCol = 3'd5;
    @(negedge clk);
    start = 1'b0;
    checkResult(3, 1, 2);
    @(negedge clk);
    checkResult(4, 4, 5);
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule